// File: doc/BRIEF.md
# NAND Flash Bus Cycle Controller

This block turns word-wide register accesses into single bus cycles on an 8-bit raw NAND flash interface. A write to the command index produces one write cycle with the command latch enable raised. A write to the address index does the same with the address latch enable raised. A write to the data index produces a plain data write cycle. A read of the data index produces a data read cycle, and the byte captured from the flash comes back on the response channel. Each cycle passes through four timed phases: setup, strobe width, hold and a final ready-wait. Every phase length comes from one packed timing word, with separate values for reads and writes.

The register side is a request stream with valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` falls for the whole of a bus cycle, and that is the only back-pressure. Responses cannot be stalled. `rsp_valid` is a one-cycle pulse that is returned for every read and never for a write. Beyond the bus sequencer, the block provides chip-enable control and a synchronized ready/busy status. It keeps two interrupt flags, each cleared by writing a one, behind an enable mask. A self-clearing software reset completes the set.

Register indices on `req_idx`: 0 data, 1 address, 2 command, 3 control, 4 configuration, 5 status, 6 flags, 7 interrupt enable, 8 flag clear, 9 timing, 10 transfer count. Reads of any index that is not listed here return zero, and so do reads of the address, command, control and clear indices.

Top module: `nfc_ctrl`

## Requirements
- R1: After reset the block is idle and holds these values:
  - `req_ready` is 1.
  - The outputs `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1.
  - The outputs `nand_cle`, `nand_ale`, `nand_dq_oe` and `irq` are 0.
  - The flag register reads 0.
  - Status reads 1 while `nand_rb` is high.
- R2: The timing word (index 9) holds eight 4-bit fields:
  - [31:28] write ready-wait
  - [27:24] write width
  - [23:20] write hold
  - [19:16] write setup
  - [15:12] read ready-wait
  - [11:8] read width
  - [7:4] read hold
  - [3:0] read setup

  A cycle runs its phases in this order:
  1. Setup: chip enable low, strobe high.
  2. Width: strobe low.
  3. Hold: strobe high, chip enable still low.
  4. Ready-wait: chip enable released.

  Each phase lasts its field value in clock cycles. A field value of 0 counts as 1.
- R3: A write to index 2 produces exactly one write cycle with `nand_cle` high and `nand_ale` low. The byte `req_wdata[7:0]` is driven with `nand_dq_oe` high from setup through hold.
- R4: A write to index 1 produces the same cycle with `nand_ale` high and `nand_cle` low.
- R5: A write to index 0 produces a write cycle with both latch enables low. Only `req_wdata[7:0]` reaches `nand_dq_out`.
- R6: A read of index 0 produces a read cycle with `nand_re_n` strobed and `nand_dq_oe` low.
  - `rsp_valid` pulses on the cycle in which `nand_re_n` rises.
  - `rsp_rdata` equals the byte on `nand_dq_in` in the last width cycle, zero-extended.
- R7: Configuration bit 5 controls chip enable.
  - When bit 5 is set, `nand_ce_n` stays low at all times.
  - When bit 5 is clear, `nand_ce_n` is low only during setup, width and hold.
- R8: `req_ready` is low from the edge that accepts a bus access to the end of its ready-wait phase. A read of any non-data index is answered with `rsp_valid` on the cycle after acceptance.
- R9: Status bit 0 (index 5) shows `nand_rb` after a two-flop synchronizer.
- R10: Flag bit 0 (index 6) is set by a rising edge of the synchronized ready/busy.
  - Writing a 1 to a bit of index 8 clears that flag.
  - `irq` is the OR of the flags masked by the enable register (index 7).
- R11: Flag bit 1 is set when the transfer count (index 10) steps from 1 to 0. The count drops by one for each completed data cycle. Command and address cycles leave it unchanged.
- R12: Writing control (index 3) with bit 2 set clears the configuration, the flags, the enable mask and the transfer count. The timing word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted; low while a bus cycle runs |
| req_write | input | 1 | 1 write, 0 read |
| req_idx | input | 4 | Register index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 32 | Read response data |
| irq | output | 1 | Masked interrupt request |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the flash |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Byte from the flash |
| nand_rb | input | 1 | Ready/busy, 1 means ready |

## Verification
The assertions check the following pin rules on every cycle:
- The two strobes are never low together, and the two latch enables are never high together.
- Any active strobe implies chip enable and a stalled request channel.
- The bus is never driven during a read strobe.
- A rising read strobe always brings a response.

The phase lengths for each field value, the byte routing and the zero-extension only show up in the bench's scenarios. The same holds for chip-enable holding, synchronizer latency, flag setting, masking and clearing, the transfer-count event and the software reset, since each depends on a programmed sequence of accesses.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int unsigned RegIdxW   = 4;
  localparam int unsigned WordW     = 32;
  localparam int unsigned ByteW     = 8;
  localparam int unsigned TimFieldW = 4;
  localparam int unsigned CountW    = 16;
  localparam int unsigned SyncDepth = 2;
  localparam int unsigned NumFlags  = 2;

  localparam logic [RegIdxW-1:0] IDX_DATA  = 4'd0;
  localparam logic [RegIdxW-1:0] IDX_ADDR  = 4'd1;
  localparam logic [RegIdxW-1:0] IDX_CMD   = 4'd2;
  localparam logic [RegIdxW-1:0] IDX_CTRL  = 4'd3;
  localparam logic [RegIdxW-1:0] IDX_CFG   = 4'd4;
  localparam logic [RegIdxW-1:0] IDX_STAT  = 4'd5;
  localparam logic [RegIdxW-1:0] IDX_FLAG  = 4'd6;
  localparam logic [RegIdxW-1:0] IDX_IEN   = 4'd7;
  localparam logic [RegIdxW-1:0] IDX_ICLR  = 4'd8;
  localparam logic [RegIdxW-1:0] IDX_TIME  = 4'd9;
  localparam logic [RegIdxW-1:0] IDX_COUNT = 4'd10;

  localparam int unsigned CfgCeHoldBit = 5;
  localparam int unsigned CtrlResetBit = 2;
  localparam int unsigned FlagRdyBit   = 0;
  localparam int unsigned FlagTcBit    = 1;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_WIDTH, PH_HOLD, PH_WAIT} phase_e;
  typedef enum logic [1:0] {KIND_DATA, KIND_CMD, KIND_ADDR} kind_e;

  // Field order is fixed by the timing word layout (write half on top).
  typedef struct packed {
    logic [TimFieldW-1:0] w_rdy;
    logic [TimFieldW-1:0] w_width;
    logic [TimFieldW-1:0] w_hold;
    logic [TimFieldW-1:0] w_setup;
    logic [TimFieldW-1:0] r_rdy;
    logic [TimFieldW-1:0] r_width;
    logic [TimFieldW-1:0] r_hold;
    logic [TimFieldW-1:0] r_setup;
  } timing_t;
endpackage

// File: rtl/nfc_sync.sv
module nfc_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= RESET_VAL;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_rd,
  input  kind_e            start_kind,
  input  logic [ByteW-1:0] start_byte,
  input  timing_t          timing,
  input  logic             ce_hold,
  input  logic [ByteW-1:0] dq_in,
  output logic             busy,
  output logic             ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic             dq_oe,
  output logic [ByteW-1:0] dq_out,
  output logic             rd_done,
  output logic [ByteW-1:0] rd_byte,
  output logic             data_done
);
  phase_e               ph_q;
  logic [TimFieldW-1:0] cnt_q;
  logic                 rd_q;
  kind_e                kind_q;
  logic [ByteW-1:0]     wbyte_q;

  logic                 rd_sel;
  logic [TimFieldW-1:0] f_setup, f_width, f_hold, f_rdy;

  // Phase length is max(field,1); the counter holds length-1.
  function automatic logic [TimFieldW-1:0] load_len(input logic [TimFieldW-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction

  always_comb begin
    rd_sel  = (ph_q == PH_IDLE) ? start_rd : rd_q;
    f_setup = rd_sel ? timing.r_setup : timing.w_setup;
    f_width = rd_sel ? timing.r_width : timing.w_width;
    f_hold  = rd_sel ? timing.r_hold  : timing.w_hold;
    f_rdy   = rd_sel ? timing.r_rdy   : timing.w_rdy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      rd_q      <= 1'b0;
      kind_q    <= KIND_DATA;
      wbyte_q   <= '0;
      rd_done   <= 1'b0;
      rd_byte   <= '0;
      data_done <= 1'b0;
    end else begin
      rd_done   <= 1'b0;
      data_done <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start) begin
          ph_q    <= PH_SETUP;
          cnt_q   <= load_len(f_setup);
          rd_q    <= start_rd;
          kind_q  <= start_kind;
          wbyte_q <= start_byte;
        end
        PH_SETUP: if (cnt_q == '0) begin
          ph_q  <= PH_WIDTH;
          cnt_q <= load_len(f_width);
        end else cnt_q <= cnt_q - 1'b1;
        PH_WIDTH: if (cnt_q == '0) begin
          ph_q  <= PH_HOLD;
          cnt_q <= load_len(f_hold);
          if (rd_q) begin
            rd_byte <= dq_in;
            rd_done <= 1'b1;
          end
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_q == '0) begin
          ph_q      <= PH_WAIT;
          cnt_q     <= load_len(f_rdy);
          data_done <= (kind_q == KIND_DATA);
        end else cnt_q <= cnt_q - 1'b1;
        PH_WAIT: if (cnt_q == '0) ph_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  logic on_bus;
  assign on_bus = (ph_q == PH_SETUP) || (ph_q == PH_WIDTH) || (ph_q == PH_HOLD);
  assign busy   = (ph_q != PH_IDLE);
  assign ce_n   = !(on_bus || ce_hold);
  assign cle    = on_bus && (kind_q == KIND_CMD);
  assign ale    = on_bus && (kind_q == KIND_ADDR);
  assign we_n   = !((ph_q == PH_WIDTH) && !rd_q);
  assign re_n   = !((ph_q == PH_WIDTH) && rd_q);
  assign dq_oe  = on_bus && !rd_q;
  assign dq_out = wbyte_q;
endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
  import nfc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [RegIdxW-1:0] idx,
  input  logic [WordW-1:0]   wdata,
  input  logic               rb_sync,
  input  logic               data_done,
  output timing_t            timing,
  output logic               ce_hold,
  output logic               rd_ack,
  output logic [WordW-1:0]   rdata,
  output logic               irq
);
  logic [WordW-1:0]    cfg_q;
  logic [NumFlags-1:0] flag_q, ien_q, set_v, clr_v;
  logic [CountW-1:0]   count_q;
  logic                rb_prev_q;
  logic                sw_rst;

  assign sw_rst = wr_en && (idx == IDX_CTRL) && wdata[CtrlResetBit];

  always_comb begin
    set_v = '0;
    set_v[FlagRdyBit] = rb_sync && !rb_prev_q;
    set_v[FlagTcBit]  = data_done && (count_q == CountW'(1));
    clr_v = (wr_en && (idx == IDX_ICLR)) ? wdata[NumFlags-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      flag_q    <= '0;
      ien_q     <= '0;
      count_q   <= '0;
      timing    <= '0;
      rb_prev_q <= 1'b1;
    end else begin
      rb_prev_q <= rb_sync;
      if (sw_rst) begin
        cfg_q   <= '0;
        flag_q  <= '0;
        ien_q   <= '0;
        count_q <= '0;
      end else begin
        flag_q <= (flag_q & ~clr_v) | set_v;
        if (data_done && count_q != '0) count_q <= count_q - 1'b1;
        if (wr_en) begin
          unique case (idx)
            IDX_CFG:   cfg_q   <= wdata;
            IDX_IEN:   ien_q   <= wdata[NumFlags-1:0];
            IDX_TIME:  timing  <= timing_t'(wdata);
            IDX_COUNT: count_q <= wdata[CountW-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack <= 1'b0;
      rdata  <= '0;
    end else begin
      rd_ack <= rd_en;
      if (rd_en) begin
        unique case (idx)
          IDX_CFG:   rdata <= cfg_q;
          IDX_STAT:  rdata <= WordW'(rb_sync);
          IDX_FLAG:  rdata <= WordW'(flag_q);
          IDX_IEN:   rdata <= WordW'(ien_q);
          IDX_TIME:  rdata <= timing;
          IDX_COUNT: rdata <= WordW'(count_q);
          default:   rdata <= '0;
        endcase
      end
    end
  end

  assign ce_hold = cfg_q[CfgCeHoldBit];
  assign irq     = |(flag_q & ien_q);
endmodule

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
  import nfc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [RegIdxW-1:0] req_idx,
  input  logic [WordW-1:0]   req_wdata,
  output logic               rsp_valid,
  output logic [WordW-1:0]   rsp_rdata,
  output logic               irq,
  output logic               nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [ByteW-1:0]   nand_dq_out,
  output logic               nand_dq_oe,
  input  logic [ByteW-1:0]   nand_dq_in,
  input  logic               nand_rb
);
  logic       acc, bus_idx, bus_start, reg_wr, reg_rd;
  logic       busy, rd_done, data_done, ce_hold, rb_sync, reg_ack;
  logic [ByteW-1:0] rd_byte;
  logic [WordW-1:0] reg_rdata;
  timing_t    timing;
  kind_e      kind;

  assign acc     = req_valid && req_ready;
  assign bus_idx = (req_idx == IDX_DATA) || (req_idx == IDX_CMD) || (req_idx == IDX_ADDR);
  assign bus_start = acc && (req_write ? bus_idx : (req_idx == IDX_DATA));
  assign reg_wr  = acc && req_write && !bus_idx;
  assign reg_rd  = acc && !req_write && (req_idx != IDX_DATA);
  assign kind    = (req_idx == IDX_CMD)  ? KIND_CMD :
                   (req_idx == IDX_ADDR) ? KIND_ADDR : KIND_DATA;

  nfc_sync #(.STAGES(SyncDepth), .RESET_VAL(1'b1)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .din(nand_rb), .dout(rb_sync));

  nfc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .start_rd(!req_write),
    .start_kind(kind), .start_byte(req_wdata[ByteW-1:0]), .timing(timing),
    .ce_hold(ce_hold), .dq_in(nand_dq_in), .busy(busy), .ce_n(nand_ce_n),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_oe(nand_dq_oe), .dq_out(nand_dq_out), .rd_done(rd_done),
    .rd_byte(rd_byte), .data_done(data_done));

  nfc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd), .idx(req_idx),
    .wdata(req_wdata), .rb_sync(rb_sync), .data_done(data_done),
    .timing(timing), .ce_hold(ce_hold), .rd_ack(reg_ack), .rdata(reg_rdata),
    .irq(irq));

  assign req_ready = !busy;
  assign rsp_valid = rd_done || reg_ack;
  assign rsp_rdata = rd_done ? {{(WordW-ByteW){1'b0}}, rd_byte} : reg_rdata;
endmodule

// File: rtl/nfc_ctrl_chk.sv
module nfc_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe
);
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_stall_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !req_ready);

  assert_ce_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> nand_re_n);

  assert_rsp_at_re_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_re_n) |-> rsp_valid);
endmodule

bind nfc_ctrl nfc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe));

// File: tb/nfc_ctrl_tb_top.sv
module nfc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb = 1'b1;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  nfc_ctrl dut_i (.*);

  // kind[41:40]: 0 command, 1 address, 2 data write, 3 data read; byte[39:32]; timing[31:0]
  localparam int NV = 6;
  localparam logic [41:0] VEC [NV] = '{
    {2'd0, 8'h90, 32'h2314_0000},
    {2'd1, 8'h3C, 32'h1121_5555},
    {2'd2, 8'hA5, 32'h0000_1111},
    {2'd3, 8'hC3, 32'h0000_3412},
    {2'd3, 8'h5A, 32'hFFFF_0000},
    {2'd2, 8'h01, 32'hF5F2_0000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int flen(input logic [3:0] f);
    return (f == 4'd0) ? 1 : int'(f);
  endfunction

  task automatic issue(input logic w, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_idx = idx; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic reg_wr(input logic [3:0] idx, input logic [31:0] d);
    issue(1'b1, idx, d);
  endtask

  task automatic reg_rd(input logic [3:0] idx, output logic [31:0] d);
    issue(1'b0, idx, '0);
    chk(rsp_valid === 1'b1, "R8 reg read response next cycle", int'(rsp_valid), 1);
    d = rsp_rdata;
  endtask

  // Run one bus access and measure its phases from the negedge after acceptance.
  task automatic bus_run(input logic [1:0] kind, input logic [7:0] b, input logic [31:0] t,
                         input bit ce_held);
    int s_n = 0, w_n = 0, h_n = 0, r_n = 0, rsp_n = 0, guard = 0;
    bit seen_low = 0, rsp_pos_ok = 0, cle_ok = 1, ale_ok = 1, oe_ok = 1, ce_ok = 1;
    logic [7:0]  obyte = '0;
    logic [31:0] rdat = '0;
    logic [3:0]  idx;
    bit rd;
    int es, ew, eh, er;
    rd  = (kind == 2'd3);
    idx = (kind == 2'd0) ? 4'd2 : (kind == 2'd1) ? 4'd1 : 4'd0;
    nand_dq_in = b;
    issue(!rd, idx, {24'hC0FFEE, b});
    while (!req_ready && guard < 300) begin
      bit sl;
      guard++;
      sl = rd ? !nand_re_n : !nand_we_n;
      if (rsp_valid) begin
        rsp_n++;
        rdat = rsp_rdata;
        rsp_pos_ok = seen_low && !sl && h_n == 0;
      end
      if (sl) begin
        w_n++; seen_low = 1; obyte = nand_dq_out;
        if (nand_cle !== (kind == 2'd0)) cle_ok = 0;
        if (nand_ale !== (kind == 2'd1)) ale_ok = 0;
        if (nand_dq_oe !== !rd) oe_ok = 0;
      end else if (!seen_low) s_n++;
      else if (!nand_ce_n && (h_n == 0 || r_n == 0) && !(ce_held && r_n > 0) &&
               (!ce_held || (nand_cle || nand_ale || nand_dq_oe || h_n < 999))) begin
        if (!ce_held) h_n++;
        else if (h_n < 0) h_n++;
        else h_n++;
      end else r_n++;
      if (ce_held && nand_ce_n) ce_ok = 0;
      @(negedge clk);
    end
    es = flen(rd ? t[3:0]   : t[19:16]);
    ew = flen(rd ? t[11:8]  : t[27:24]);
    eh = flen(rd ? t[7:4]   : t[23:20]);
    er = flen(rd ? t[15:12] : t[31:28]);
    if (ce_held) begin
      chk(ce_ok, "R7 chip enable held low through cycle", int'(ce_ok), 1);
      chk(s_n + w_n + h_n + r_n == es + ew + eh + er, "R8 busy length with ce held",
          s_n + w_n + h_n + r_n, es + ew + eh + er);
    end else begin
      chk(s_n == es, "R2 setup length", s_n, es);
      chk(w_n == ew, "R2 width length", w_n, ew);
      chk(h_n == eh, "R2 hold length", h_n, eh);
      chk(r_n == er, "R8 ready-wait stall length", r_n, er);
    end
    chk(cle_ok, "R3 cle level during strobe", int'(cle_ok), 1);
    chk(ale_ok, "R4 ale level during strobe", int'(ale_ok), 1);
    if (rd) begin
      chk(oe_ok, "R6 bus not driven on read", int'(oe_ok), 1);
      chk(rsp_n == 1 && rsp_pos_ok, "R6 one response at read strobe rise", rsp_n, 1);
      chk(rdat == {24'h0, b}, "R6 read data zero-extended", int'(rdat), int'({24'h0, b}));
    end else begin
      chk(oe_ok, "R5 bus driven on write", int'(oe_ok), 1);
      chk(obyte == b, "R5 only low byte driven", int'(obyte), int'(b));
      chk(rsp_n == 0, "R8 no response for write", rsp_n, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk({nand_ce_n, nand_we_n, nand_re_n} === 3'b111, "R1 strobes idle",
        int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
    chk({nand_cle, nand_ale, nand_dq_oe, irq} === 4'b0, "R1 enables idle",
        int'({nand_cle, nand_ale, nand_dq_oe, irq}), 0);
    reg_rd(4'd6, d); chk(d == 0, "R1 flags clear", int'(d), 0);
    reg_rd(4'd5, d); chk(d == 1, "R1 R9 status ready", int'(d), 1);

    // Vector table: R2..R6, R8
    for (int i = 0; i < NV; i++) begin
      reg_wr(4'd9, VEC[i][31:0]);
      bus_run(VEC[i][41:40], VEC[i][39:32], VEC[i][31:0], 1'b0);
    end

    // R7 chip enable hold
    reg_wr(4'd4, 32'h20);
    chk(nand_ce_n === 1'b0, "R7 ce low while idle with hold set", int'(nand_ce_n), 0);
    reg_wr(4'd9, 32'h2222_2222);
    bus_run(2'd0, 8'h11, 32'h2222_2222, 1'b1);
    chk(nand_ce_n === 1'b0, "R7 ce still low after cycle", int'(nand_ce_n), 0);
    reg_wr(4'd4, 32'h0);
    chk(nand_ce_n === 1'b1, "R7 ce released when hold clear", int'(nand_ce_n), 1);

    // R9 status follows ready/busy
    nand_rb = 1'b0;
    repeat (4) @(negedge clk);
    reg_rd(4'd5, d); chk(d == 0, "R9 status busy", int'(d), 0);

    // R10 ready flag, mask, clear
    reg_wr(4'd7, 32'h1);
    chk(irq === 1'b0, "R10 no irq before rise", int'(irq), 0);
    nand_rb = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq === 1'b1, "R10 irq on ready rise", int'(irq), 1);
    reg_rd(4'd6, d); chk(d == 1, "R10 ready flag set", int'(d), 1);
    reg_wr(4'd8, 32'h1);
    reg_rd(4'd6, d); chk(d == 0, "R10 flag cleared by one", int'(d), 0);
    chk(irq === 1'b0, "R10 irq dropped after clear", int'(irq), 0);
    reg_wr(4'd7, 32'h0);
    nand_rb = 1'b0; repeat (4) @(negedge clk);
    nand_rb = 1'b1; repeat (4) @(negedge clk);
    chk(irq === 1'b0, "R10 masked flag gives no irq", int'(irq), 0);
    reg_rd(4'd6, d); chk(d == 1, "R10 flag set while masked", int'(d), 1);
    reg_wr(4'd8, 32'h1);

    // R11 transfer count
    reg_wr(4'd9, 32'h0);
    reg_wr(4'd10, 32'd2);
    reg_wr(4'd7, 32'h2);
    bus_run(2'd0, 8'h80, 32'h0, 1'b0);
    bus_run(2'd2, 8'h33, 32'h0, 1'b0);
    reg_rd(4'd6, d); chk(d == 0, "R11 no event before zero, cmd not counted", int'(d), 0);
    reg_rd(4'd10, d); chk(d == 1, "R11 count after one data cycle", int'(d), 1);
    bus_run(2'd3, 8'h44, 32'h0, 1'b0);
    reg_rd(4'd6, d); chk(d == 2, "R11 count event at zero", int'(d), 2);
    chk(irq === 1'b1, "R11 irq from count event", int'(irq), 1);

    // R12 software reset
    reg_wr(4'd9, 32'h1234_5678);
    reg_wr(4'd4, 32'h20);
    reg_wr(4'd10, 32'd9);
    reg_wr(4'd3, 32'h4);
    reg_rd(4'd4, d);  chk(d == 0, "R12 config cleared", int'(d), 0);
    reg_rd(4'd6, d);  chk(d == 0, "R12 flags cleared", int'(d), 0);
    reg_rd(4'd7, d);  chk(d == 0, "R12 enable cleared", int'(d), 0);
    reg_rd(4'd10, d); chk(d == 0, "R12 count cleared", int'(d), 0);
    reg_rd(4'd9, d);  chk(d == 32'h1234_5678, "R12 timing kept", int'(d), 32'h1234_5678);
    chk(nand_ce_n === 1'b1 && irq === 1'b0, "R12 pins idle after reset",
        int'({nand_ce_n, irq}), 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule